// File: doc/BRIEF.md
# Special-Purpose Register Access Unit

This block is the move-to and move-from path of a small RISC core's special-purpose register space. Each access forms a 16-bit register address by ORing the low half of a base register value with a 16-bit immediate. The upper five bits of that address select a group, and the lower eleven bits select a register within the group. The core presents one access per cycle on `acc_valid`, with `acc_write` choosing between a store of `wr_data` and a load into `rd_data`. Every access completes in the cycle it is presented.

Group 0 holds the system registers:
- Read-only identification and configuration constants.
- The next and previous program counters.
- The exception return, address and status registers.
- The status register (SR). One bit of SR is always one. Its data-MMU and instruction-MMU enable bits drive the address-mode outputs directly.

Groups 1 and 2 hold the way-0 match and translate arrays of the data-side and instruction-side TLBs.

A status write that changes the MMU enables or the supervisor bit raises a one-cycle TLB-flush pulse. A write to a match register raises a one-cycle page-invalidate pulse that carries the page of the value being replaced. A read of any address that maps to nothing returns the core's old destination value, so that register keeps its value. The block has no state machine. A combinational decoder sorts each address into a register kind, and a `unique case` on that kind selects the read source and the write target.

Top module: `spr_access_unit`

## Requirements
- R1: The register address is `base_val[15:0] | imm_ofs`. The group is address bits 15:11 and the register number is bits 10:0, so address = group*2048 + number.
- R2: Group 0 numbers 16, 18, 32, 48 and 64 are writable 32-bit registers. A write stores `wr_data`, and a later read returns that value in `rd_data` in the same cycle as the read.
- R3: SR is group 0 number 17. After any SR write, SR reads back as the written value with bit 15 forced to 1.
- R4: If an SR write changes bit 0 (supervisor), bit 5 (data MMU enable) or bit 6 (instruction MMU enable), `tlb_flush` is high for exactly the next cycle. An SR write that changes none of these bits leaves `tlb_flush` low.
- R5: `dmmu_xlate_en` equals SR bit 5 and `immu_xlate_en` equals SR bit 6 (1 = translated, 0 = pass-through).
- R6: The data-TLB way-0 match entries sit at group 1 numbers 512 to 512+TLB_SETS-1, and the translate entries at numbers 640 to 640+TLB_SETS-1. The instruction TLB uses the same numbers in group 2. Each entry reads back the last value written to it.
- R7: Writes to group 1 or group 2 numbers 768 to 1535 change nothing. A read there returns `dest_old`.
- R8: A match-entry write pulses `inval_valid` for exactly the next cycle. During that cycle `inval_page` is the entry's previous value with its low PAGE_BITS bits cleared, and `inval_dside` is 1 for the data TLB or 0 for the instruction TLB. The entry holds the new value from then on.
- R9: Number 0 reads VR_VALUE & VR_MASK. Numbers 1, 2, 3 and 4 read the UPR, CPU, DMMU and IMMU configuration constants. Writes to numbers 0 to 4 are dropped.
- R10: A read of any address not mapped by R2, R3, R6 or R9, including group 1/2 numbers 512+TLB_SETS to 639 and 640+TLB_SETS to 767, returns `dest_old` unchanged.
- R11: After reset, SR is 0x0000_8001 (supervisor and the fixed bit set, both MMUs off). The other writable system registers and all TLB entries read 0. `tlb_flush` and `inval_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = move to register, 0 = move from register |
| base_val | input | 32 | Base register value (low 16 bits form the address) |
| imm_ofs | input | 16 | Immediate ORed into the address |
| wr_data | input | 32 | Value to store on a write |
| dest_old | input | 32 | Current destination value, returned for unmapped reads |
| rd_data | output | 32 | Read result (dest_old when nothing maps or no read is presented) |
| sr_value | output | 32 | Current status register |
| tlb_flush | output | 1 | One-cycle full TLB flush request |
| dmmu_xlate_en | output | 1 | Data-side translation enable |
| immu_xlate_en | output | 1 | Instruction-side translation enable |
| inval_valid | output | 1 | One-cycle page invalidate request |
| inval_dside | output | 1 | 1 = invalidate in data TLB, 0 = instruction TLB |
| inval_page | output | 32 | Page address to invalidate |

## Verification
The embedded assertions check the following on every cycle:
- A flush follows every SR write that changes the supervisor or MMU-enable bits, and appears at no other time.
- The fixed SR bit is set after every SR write.
- An invalidate pulse follows each match-entry write, carries the page of the replaced value, and appears at no other time.
- The translation-enable outputs change only after a write.

Only the bench's scenarios can show the rest:
- Values written to one register read back from that register and from no neighbour.
- The way-1 to way-3 window and the gaps past TLB_SETS stay inert.
- The constants are masked correctly.
- The OR-formed address selects the intended register.

// File: rtl/spr_pkg.sv
package spr_pkg;

    typedef enum logic [3:0] {
        K_NONE,
        K_VR,
        K_UPR,
        K_CPUCFG,
        K_DMMUCFG,
        K_IMMUCFG,
        K_NPC,
        K_SR,
        K_PPC,
        K_EPCR,
        K_EEAR,
        K_ESR,
        K_MATCH,
        K_XLATE
    } spr_kind_e;

    // Status register bit positions used by neighbouring logic
    localparam int SR_SM  = 0;
    localparam int SR_DME = 5;
    localparam int SR_IME = 6;
    localparam int SR_FO  = 15;

    localparam logic [31:0] SR_RESET   = (32'd1 << SR_FO) | (32'd1 << SR_SM);
    localparam logic [31:0] SR_FLUSH_M = (32'd1 << SR_SM) | (32'd1 << SR_DME) | (32'd1 << SR_IME);

    localparam int GROUP_SYS  = 0;
    localparam int GROUP_DTLB = 1;
    localparam int GROUP_ITLB = 2;
    localparam int MATCH_BASE = 512;
    localparam int XLATE_BASE = 640;
    localparam int WAY_WINDOW = 128;

endpackage

// File: rtl/spr_addr_decode.sv
module spr_addr_decode
    import spr_pkg::*;
#(
    parameter int TLB_SETS = 64,
    localparam int IDXW = (TLB_SETS > 1) ? $clog2(TLB_SETS) : 1
) (
    input  logic [15:0]     addr,
    output spr_kind_e       kind,
    output logic            dside,
    output logic [IDXW-1:0] idx
);

    logic [4:0]  grp;
    logic [10:0] num;
    logic [10:0] m_off;
    logic [10:0] x_off;

    assign grp   = addr[15:11];
    assign num   = addr[10:0];
    assign m_off = num - 11'(MATCH_BASE);
    assign x_off = num - 11'(XLATE_BASE);

    always_comb begin
        kind  = K_NONE;
        dside = (grp == 5'(GROUP_DTLB));
        idx   = '0;
        if (grp == 5'(GROUP_SYS)) begin
            unique case (num)
                11'd0:   kind = K_VR;
                11'd1:   kind = K_UPR;
                11'd2:   kind = K_CPUCFG;
                11'd3:   kind = K_DMMUCFG;
                11'd4:   kind = K_IMMUCFG;
                11'd16:  kind = K_NPC;
                11'd17:  kind = K_SR;
                11'd18:  kind = K_PPC;
                11'd32:  kind = K_EPCR;
                11'd48:  kind = K_EEAR;
                11'd64:  kind = K_ESR;
                default: kind = K_NONE;
            endcase
        end else if (grp == 5'(GROUP_DTLB) || grp == 5'(GROUP_ITLB)) begin
            if (num >= 11'(MATCH_BASE) && num < 11'(MATCH_BASE + TLB_SETS)) begin
                kind = K_MATCH;
                idx  = IDXW'(m_off);
            end else if (num >= 11'(XLATE_BASE) && num < 11'(XLATE_BASE + TLB_SETS)) begin
                kind = K_XLATE;
                idx  = IDXW'(x_off);
            end
        end
    end

    // R7: nothing in the way-1..3 window may decode to a TLB entry
    always_comb begin
        a_r7_upper_ways_unmapped: assert (!(num >= 11'd768 && grp != 5'd0) || kind == K_NONE);
    end

endmodule

// File: rtl/spr_sys_regs.sv
module spr_sys_regs
    import spr_pkg::*;
#(
    parameter int          XLEN        = 32,
    parameter logic [31:0] VR_VALUE    = 32'h1234_00FF,
    parameter logic [31:0] VR_MASK     = 32'hFFFF_003F,
    parameter logic [31:0] UPR_VALUE   = 32'h0000_0619,
    parameter logic [31:0] CPUCFG_VAL  = 32'h0000_0020,
    parameter logic [31:0] DMMUCFG_VAL = 32'h0000_0018,
    parameter logic [31:0] IMMUCFG_VAL = 32'h0000_0018
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  spr_kind_e       kind,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] sr_q,
    output logic            flush_q,
    output logic            hit,
    output logic [XLEN-1:0] rd_val
);

    logic [XLEN-1:0] npc_q, ppc_q, epcr_q, eear_q, esr_q;
    logic            sr_wr;
    logic            sr_mode_change;

    assign sr_wr          = wr_en && (kind == K_SR);
    assign sr_mode_change = |((sr_q ^ wr_data) & XLEN'(SR_FLUSH_M));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q    <= XLEN'(SR_RESET);
            npc_q   <= '0;
            ppc_q   <= '0;
            epcr_q  <= '0;
            eear_q  <= '0;
            esr_q   <= '0;
            flush_q <= 1'b0;
        end else begin
            flush_q <= sr_wr && sr_mode_change;
            if (wr_en) begin
                unique case (kind)
                    K_SR:    sr_q   <= wr_data | (XLEN'(1) << SR_FO);
                    K_NPC:   npc_q  <= wr_data;
                    K_PPC:   ppc_q  <= wr_data;
                    K_EPCR:  epcr_q <= wr_data;
                    K_EEAR:  eear_q <= wr_data;
                    K_ESR:   esr_q  <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        hit    = 1'b1;
        rd_val = '0;
        unique case (kind)
            K_VR:      rd_val = XLEN'(VR_VALUE & VR_MASK);
            K_UPR:     rd_val = XLEN'(UPR_VALUE);
            K_CPUCFG:  rd_val = XLEN'(CPUCFG_VAL);
            K_DMMUCFG: rd_val = XLEN'(DMMUCFG_VAL);
            K_IMMUCFG: rd_val = XLEN'(IMMUCFG_VAL);
            K_NPC:     rd_val = npc_q;
            K_SR:      rd_val = sr_q;
            K_PPC:     rd_val = ppc_q;
            K_EPCR:    rd_val = epcr_q;
            K_EEAR:    rd_val = eear_q;
            K_ESR:     rd_val = esr_q;
            default:   hit    = 1'b0;
        endcase
    end

    a_r3_fixed_bit_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr |=> sr_q[SR_FO]);

    a_r4_flush_on_mode_change: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr && ((sr_q[SR_SM] != wr_data[SR_SM]) || (sr_q[SR_DME] != wr_data[SR_DME])
                   || (sr_q[SR_IME] != wr_data[SR_IME]))) |=> flush_q);

    a_r4_flush_only_after_sr_write: assert property (@(posedge clk) disable iff (!rst_n)
        flush_q |-> $past(sr_wr));

endmodule

// File: rtl/spr_tlb_way0.sv
module spr_tlb_way0 #(
    parameter int XLEN      = 32,
    parameter int TLB_SETS  = 64,
    parameter int PAGE_BITS = 13,
    localparam int IDXW = (TLB_SETS > 1) ? $clog2(TLB_SETS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_match,
    input  logic            wr_xlate,
    input  logic [IDXW-1:0] idx,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] rd_match,
    output logic [XLEN-1:0] rd_xlate,
    output logic            inval_q,
    output logic [XLEN-1:0] inval_page_q
);

    localparam logic [XLEN-1:0] PAGE_MASK = ~((XLEN'(1) << PAGE_BITS) - XLEN'(1));

    logic [XLEN-1:0] match_q [TLB_SETS];
    logic [XLEN-1:0] xlate_q [TLB_SETS];

    assign rd_match = match_q[idx];
    assign rd_xlate = xlate_q[idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TLB_SETS; i++) begin
                match_q[i] <= '0;
                xlate_q[i] <= '0;
            end
            inval_q      <= 1'b0;
            inval_page_q <= '0;
        end else begin
            inval_q <= wr_match;
            if (wr_match) begin
                inval_page_q <= match_q[idx] & PAGE_MASK;
                match_q[idx] <= wr_data;
            end
            if (wr_xlate) begin
                xlate_q[idx] <= wr_data;
            end
        end
    end

    a_r8_inval_follows_match_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_match |=> inval_q);

    a_r8_inval_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        inval_q |-> $past(wr_match));

    a_r8_inval_old_page: assert property (@(posedge clk) disable iff (!rst_n)
        wr_match |=> (inval_page_q == ($past(rd_match) & PAGE_MASK)));

endmodule

// File: rtl/spr_access_unit.sv
module spr_access_unit
    import spr_pkg::*;
#(
    parameter int          TLB_SETS    = 64,
    parameter int          PAGE_BITS   = 13,
    parameter logic [31:0] VR_VALUE    = 32'h1234_00FF,
    parameter logic [31:0] VR_MASK     = 32'hFFFF_003F,
    parameter logic [31:0] UPR_VALUE   = 32'h0000_0619,
    parameter logic [31:0] CPUCFG_VAL  = 32'h0000_0020,
    parameter logic [31:0] DMMUCFG_VAL = 32'h0000_0018,
    parameter logic [31:0] IMMUCFG_VAL = 32'h0000_0018
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [31:0] base_val,
    input  logic [15:0] imm_ofs,
    input  logic [31:0] wr_data,
    input  logic [31:0] dest_old,
    output logic [31:0] rd_data,
    output logic [31:0] sr_value,
    output logic        tlb_flush,
    output logic        dmmu_xlate_en,
    output logic        immu_xlate_en,
    output logic        inval_valid,
    output logic        inval_dside,
    output logic [31:0] inval_page
);

    localparam int XLEN  = 32;
    localparam int IDXW  = (TLB_SETS > 1) ? $clog2(TLB_SETS) : 1;
    localparam int NSIDE = 2;   // 0 = data TLB, 1 = instruction TLB

    initial begin
        a_sets_fit_window: assert (TLB_SETS >= 1 && TLB_SETS <= WAY_WINDOW);
    end

    logic [15:0]     spr_addr;
    spr_kind_e       kind;
    logic            dside;
    logic [IDXW-1:0] idx;
    logic            wr_en;
    logic            rd_en;
    logic            sys_hit;
    logic [XLEN-1:0] sys_rd;

    logic [XLEN-1:0] t_rd_match [NSIDE];
    logic [XLEN-1:0] t_rd_xlate [NSIDE];
    logic            t_inval    [NSIDE];
    logic [XLEN-1:0] t_page     [NSIDE];

    assign spr_addr = base_val[15:0] | imm_ofs;
    assign wr_en    = acc_valid && acc_write;
    assign rd_en    = acc_valid && !acc_write;

    spr_addr_decode #(.TLB_SETS(TLB_SETS)) u_decode (
        .addr  (spr_addr),
        .kind  (kind),
        .dside (dside),
        .idx   (idx)
    );

    spr_sys_regs #(
        .XLEN        (XLEN),
        .VR_VALUE    (VR_VALUE),
        .VR_MASK     (VR_MASK),
        .UPR_VALUE   (UPR_VALUE),
        .CPUCFG_VAL  (CPUCFG_VAL),
        .DMMUCFG_VAL (DMMUCFG_VAL),
        .IMMUCFG_VAL (IMMUCFG_VAL)
    ) u_sys (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .kind    (kind),
        .wr_data (wr_data),
        .sr_q    (sr_value),
        .flush_q (tlb_flush),
        .hit     (sys_hit),
        .rd_val  (sys_rd)
    );

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        logic side_sel;
        assign side_sel = (s == 0) ? dside : !dside;

        spr_tlb_way0 #(
            .XLEN      (XLEN),
            .TLB_SETS  (TLB_SETS),
            .PAGE_BITS (PAGE_BITS)
        ) u_tlb (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_match     (wr_en && side_sel && kind == K_MATCH),
            .wr_xlate     (wr_en && side_sel && kind == K_XLATE),
            .idx          (idx),
            .wr_data      (wr_data),
            .rd_match     (t_rd_match[s]),
            .rd_xlate     (t_rd_xlate[s]),
            .inval_q      (t_inval[s]),
            .inval_page_q (t_page[s])
        );
    end

    always_comb begin
        rd_data = dest_old;
        if (rd_en) begin
            unique case (kind)
                K_MATCH: rd_data = dside ? t_rd_match[0] : t_rd_match[1];
                K_XLATE: rd_data = dside ? t_rd_xlate[0] : t_rd_xlate[1];
                default: if (sys_hit) rd_data = sys_rd;
            endcase
        end
    end

    assign inval_valid   = t_inval[0] || t_inval[1];
    assign inval_dside   = t_inval[0];
    assign inval_page    = t_inval[0] ? t_page[0] : t_page[1];
    assign dmmu_xlate_en = sr_value[SR_DME];
    assign immu_xlate_en = sr_value[SR_IME];

    // R5: translation modes only move after a register write
    a_r5_mode_changes_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(dmmu_xlate_en) || !$stable(immu_xlate_en)) |-> $past(wr_en));

    // R8: both sides never invalidate together
    a_r8_single_side: assert property (@(posedge clk) disable iff (!rst_n)
        !(t_inval[0] && t_inval[1]));

endmodule

// File: tb/test_spr_access_unit.sv
module test_spr_access_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] base_val = '0;
    logic [15:0] imm_ofs = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] dest_old = '0;
    logic [31:0] rd_data;
    logic [31:0] sr_value;
    logic        tlb_flush;
    logic        dmmu_xlate_en;
    logic        immu_xlate_en;
    logic        inval_valid;
    logic        inval_dside;
    logic [31:0] inval_page;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    spr_access_unit i_spr_access_unit (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .base_val(base_val), .imm_ofs(imm_ofs), .wr_data(wr_data), .dest_old(dest_old),
        .rd_data(rd_data), .sr_value(sr_value), .tlb_flush(tlb_flush),
        .dmmu_xlate_en(dmmu_xlate_en), .immu_xlate_en(immu_xlate_en),
        .inval_valid(inval_valid), .inval_dside(inval_dside), .inval_page(inval_page)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] base;
        logic [15:0] imm;
        logic [31:0] data;
        logic [31:0] old;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t TABLE [NV] = '{
        '{1'b1, 32'h0,      16'h0010, 32'hA5A5_0001, 32'h0, 32'h0},           // R2 NPC write
        '{1'b0, 32'h0,      16'h0010, 32'h0, 32'h0, 32'hA5A5_0001},           // R2 NPC read
        '{1'b1, 32'h0020,   16'h0000, 32'h1111_2222, 32'h0, 32'h0},           // R1 EPCR via base
        '{1'b0, 32'hFFFF_0000, 16'h0020, 32'h0, 32'h0, 32'h1111_2222},        // R1 upper base bits unused
        '{1'b1, 32'h0030,   16'h0010, 32'hCAFE_0000, 32'h0, 32'h0},           // R1 OR forms 0x30
        '{1'b0, 32'h0,      16'h0030, 32'h0, 32'h0, 32'hCAFE_0000},           // R2 EEAR
        '{1'b1, 32'h0,      16'h0040, 32'h0000_0BAD, 32'h0, 32'h0},           // R2 ESR
        '{1'b0, 32'h0,      16'h0040, 32'h0, 32'h0, 32'h0000_0BAD},
        '{1'b1, 32'h0002,   16'h0010, 32'h0040_0000, 32'h0, 32'h0},           // R2 PPC
        '{1'b0, 32'h0,      16'h0012, 32'h0, 32'h0, 32'h0040_0000},
        '{1'b0, 32'h0,      16'h0000, 32'h0, 32'hDEAD, 32'h1234_003F},        // R9 VR masked
        '{1'b1, 32'h0,      16'h0000, 32'h0, 32'h0, 32'h0},                   // R9 VR write dropped
        '{1'b0, 32'h0,      16'h0000, 32'h0, 32'h0, 32'h1234_003F},
        '{1'b0, 32'h0,      16'h0001, 32'h0, 32'h0, 32'h0000_0619},           // R9 UPR
        '{1'b1, 32'h0,      16'h0002, 32'hFFFF_FFFF, 32'h0, 32'h0},           // R9 CPU cfg write dropped
        '{1'b0, 32'h0,      16'h0002, 32'h0, 32'h0, 32'h0000_0020},
        '{1'b0, 32'h0,      16'h0003, 32'h0, 32'h0, 32'h0000_0018},
        '{1'b0, 32'h0,      16'h0004, 32'h0, 32'h0, 32'h0000_0018},
        '{1'b0, 32'h0,      16'h0005, 32'h0, 32'h77, 32'h77},                 // R10 unmapped group 0
        '{1'b1, 32'h0,      16'h0A00, 32'h0000_2001, 32'h0, 32'h0},           // R6 DTLB match 0
        '{1'b0, 32'h0,      16'h0A00, 32'h0, 32'h0, 32'h0000_2001},
        '{1'b1, 32'h0,      16'h0A83, 32'h1234_5000, 32'h0, 32'h0},           // R6 DTLB xlate 3
        '{1'b0, 32'h0,      16'h0A83, 32'h0, 32'h0, 32'h1234_5000},
        '{1'b1, 32'h0,      16'h123F, 32'hFFFF_E001, 32'h0, 32'h0},           // R6 ITLB match 63
        '{1'b0, 32'h0,      16'h123F, 32'h0, 32'h0, 32'hFFFF_E001},
        '{1'b1, 32'h0,      16'h0B00, 32'hFFFF_FFFF, 32'h0, 32'h0},           // R7 way-1 write ignored
        '{1'b0, 32'h0,      16'h0B00, 32'h0, 32'h55, 32'h55},                 // R7 way-1 read
        '{1'b0, 32'h0,      16'h0A00, 32'h0, 32'h0, 32'h0000_2001},           // R7 way-0 untouched
        '{1'b0, 32'h0,      16'h0A40, 32'h0, 32'h66, 32'h66},                 // R10 past TLB_SETS
        '{1'b0, 32'h0,      16'h0A01, 32'h0, 32'h99, 32'h0}                   // R11 entry reset 0
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at negedge, capture combinational read before the edge,
    // return at the following negedge (registered pulses visible then).
    task automatic access(input logic wr, input logic [31:0] b, input logic [15:0] im,
                          input logic [31:0] d, input logic [31:0] old,
                          output logic [31:0] rd);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; base_val = b; imm_ofs = im;
        wr_data = d; dest_old = old;
        #1 rd = rd_data;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check("R11 sr", sr_value, 32'h0000_8001);
        check("R11 flush", {31'd0, tlb_flush}, 32'd0);
        check("R11 inval", {31'd0, inval_valid}, 32'd0);
        check("R5 reset modes", {30'd0, immu_xlate_en, dmmu_xlate_en}, 32'd0);
        access(1'b0, 32'h0, 16'h0010, 32'h0, 32'h5, r);
        check("R11 npc", r, 32'h0);

        for (int i = 0; i < NV; i++) begin
            access(TABLE[i].wr, TABLE[i].base, TABLE[i].imm, TABLE[i].data, TABLE[i].old, r);
            if (!TABLE[i].wr) check($sformatf("table[%0d]", i), r, TABLE[i].exp);
        end

        // R3/R4: SR write keeping mode bits -> no flush, FO forced
        access(1'b1, 32'h0, 16'h0011, 32'h0000_0001, 32'h0, r);
        check("R4 no flush same mode", {31'd0, tlb_flush}, 32'd0);
        access(1'b0, 32'h0, 16'h0011, 32'h0, 32'h0, r);
        check("R3 fo forced", r, 32'h0000_8001);

        // R4/R5: enable both MMUs
        access(1'b1, 32'h0, 16'h0011, 32'h0000_0061, 32'h0, r);
        check("R4 flush on mmu enable", {31'd0, tlb_flush}, 32'd1);
        check("R5 modes on", {30'd0, immu_xlate_en, dmmu_xlate_en}, 32'd3);
        @(negedge clk);
        check("R4 flush one cycle", {31'd0, tlb_flush}, 32'd0);

        // R4: drop supervisor only
        access(1'b1, 32'h0, 16'h0011, 32'h0000_0060, 32'h0, r);
        check("R4 flush on sm change", {31'd0, tlb_flush}, 32'd1);

        // R4: unrelated bit change
        access(1'b1, 32'h0, 16'h0011, 32'h0000_0260, 32'h0, r);
        check("R4 no flush other bit", {31'd0, tlb_flush}, 32'd0);
        access(1'b0, 32'h0, 16'h0011, 32'h0, 32'h0, r);
        check("R3 sr readback", r, 32'h0000_8260);

        // R5: disable data MMU only
        access(1'b1, 32'h0, 16'h0011, 32'h0000_0040, 32'h0, r);
        check("R5 dmmu off immu on", {30'd0, immu_xlate_en, dmmu_xlate_en}, 32'd2);

        // R8: data match rewrite invalidates old page 0x2000
        access(1'b1, 32'h0, 16'h0A00, 32'h0000_4001, 32'h0, r);
        check("R8 inval valid d", {31'd0, inval_valid}, 32'd1);
        check("R8 inval side d", {31'd0, inval_dside}, 32'd1);
        check("R8 inval page d", inval_page, 32'h0000_2000);
        @(negedge clk);
        check("R8 inval one cycle", {31'd0, inval_valid}, 32'd0);
        access(1'b0, 32'h0, 16'h0A00, 32'h0, 32'h0, r);
        check("R8 new value stored", r, 32'h0000_4001);

        // R8: instruction match rewrite
        access(1'b1, 32'h0, 16'h123F, 32'h0, 32'h0, r);
        check("R8 inval valid i", {31'd0, inval_valid}, 32'd1);
        check("R8 inval side i", {31'd0, inval_dside}, 32'd0);
        check("R8 inval page i", inval_page, 32'hFFFF_E000);

        // R8: translate write raises no invalidate
        access(1'b1, 32'h0, 16'h1280, 32'h0BAD_0000, 32'h0, r);
        check("R8 xlate no inval", {31'd0, inval_valid}, 32'd0);
        access(1'b0, 32'h0, 16'h1280, 32'h0, 32'h0, r);
        check("R6 itlb xlate", r, 32'h0BAD_0000);

        // R7: ITLB way-3 write ignored, way-0 entry intact
        access(1'b1, 32'h0, 16'h15FF, 32'h1234_5678, 32'h0, r);
        check("R7 no inval upper way", {31'd0, inval_valid}, 32'd0);
        access(1'b0, 32'h0, 16'h1280, 32'h0, 32'h0, r);
        check("R7 itlb intact", r, 32'h0BAD_0000);

        // R10: unmapped group
        access(1'b0, 32'h0, 16'h1800, 32'h0, 32'hABCD, r);
        check("R10 group 3", r, 32'h0000_ABCD);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule